// File: doc/BRIEF.md
# Protected Page-Write Commit Unit

This block sits behind a two-wire serial slave front end and handles the write side of a 256-byte non-volatile store. The front end passes one event per completed byte: a select byte seen after a START, the address byte, each data byte, or a STOP. Each event carries a kind code and a byte value. For every select, address and data byte the unit returns an acknowledge or no-acknowledge decision, which the front end drives onto the bus in the ninth bit slot. Accepted data bytes are staged in a one-row buffer of 16 bytes. A STOP that the front end marks as lying in the slot right after an acknowledge starts a self-timed write cycle. That cycle copies the staged bytes into the array and holds `busy` high while it runs.

Two controls restrict writes. The `wr_inhibit` pin refuses every data byte while it is high. A one-time lock flag refuses data bytes aimed at the lower half of the array (addresses 00h to 7Fh). The lock is set by a write to a separate protection target. Once set, it is never cleared: neither a command, nor the pin, nor reset clears it. A read port gives the read side of the chip access to the array. The bit-level bus logic and the read sequencing are outside this block.

Event interface rules: the front end holds `ev_valid` with a stable kind and byte until `ev_ready` is high at a clock edge. Each accepted select, address or data event is answered by a one-cycle `resp_valid` pulse in the following cycle, and `ev_ready` is low during that cycle. A STOP is answered by nothing. The unit never stalls for any other reason. Events that arrive while a write cycle runs are accepted and refused.

Top module: `prot_page_commit`

## Requirements
- R1: A select byte is acknowledged only when all of these hold: bits [7:4] are 1010 (array target) or 0110 (protection target, only while the lock is clear); bits [3:1] equal `dev_sel`; bit 0 is 0 (write); and `busy` is low. Any other select byte is refused and closes the session.
- R2: After an acknowledged select, the next address byte is acknowledged whatever the level of `wr_inhibit`. Its bits [7:4] fix the row and its bits [3:0] set the start slot.
- R3: In an array session, a data byte is acknowledged only when `wr_inhibit` is low and the lock does not cover the current address (the lock covers addresses whose bit 7 is 0).
- R4: After each data byte, only the low four bits of the address advance. The write pointer wraps inside the same 16-byte row, and a later byte for a slot replaces an earlier one.
- R5: A write cycle starts only on a STOP whose byte bit 0 is 1 (the STOP lies right after an acknowledge slot) and whose preceding event in the session was an acknowledged data byte. Any other STOP discards the staged bytes and leaves the array unchanged.
- R6: During a write cycle, row slots that received no acknowledged byte keep their old array contents.
- R7: `busy` rises in the cycle after a committing STOP is accepted and stays high for exactly WR_CYCLES cycles. Every select, address or data event accepted while `busy` is high is refused.
- R8: In a protection session, data bytes are acknowledged only when `wr_inhibit` is low, and their values are ignored. A committing STOP sets the lock. After that, selects with type 0110 are refused, data bytes for the lower half are refused, and the upper half stays writable.
- R9: The lock and the array contents survive reset. Reset empties the staging buffer and ends any open session, so a STOP after reset commits nothing.
- R10: A select, address or data event accepted at one clock edge is answered by `resp_valid` high for the following cycle only, with `ev_ready` low in that cycle. A STOP produces no response.
- R11: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is presented.
- R12: Address or data events that arrive without an open session are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (array and lock are kept) |
| ev_valid | input | 1 | Byte event offered by the front end |
| ev_ready | output | 1 | Unit can accept an event this cycle |
| ev_kind | input | 2 | 0 select, 1 address, 2 data, 3 STOP |
| ev_byte | input | 8 | Byte value; for STOP, bit 0 = 1 means the STOP lies right after an acknowledge slot |
| resp_valid | output | 1 | Decision for the last accepted non-STOP event |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| dev_sel | input | 3 | Chip address to match in select bits [3:1] |
| wr_inhibit | input | 1 | High refuses all data bytes |
| busy | output | 1 | Self-timed write cycle running |
| rd_addr | input | 8 | Read side array address |
| rd_data | output | 8 | Array byte, one cycle after rd_addr |

## Verification
On every cycle, the assertions check these properties: no acknowledge leaves while the write cycle runs; no data acknowledge leaves while the inhibit pin is high; the lock never falls once set; a response appears only after an accepted non-STOP event; and no array write lands in the lower half once the lock is set. Other behaviours show only as array contents read back after a full sequence, so only the directed scenarios can show them. These are the row wrap and the last-byte-wins order, the survival of unacknowledged slots, discard on a misplaced STOP, the exact length of the busy window, and persistence across reset.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    EV_SEL = 2'd0,
    EV_ADR = 2'd1,
    EV_DAT = 2'd2,
    EV_STP = 2'd3
  } ev_kind_t;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_ADDR = 2'd1,
    SS_DATA = 2'd2
  } sess_t;

  localparam logic [3:0] TYPE_ARRAY = 4'b1010;
  localparam logic [3:0] TYPE_PROT  = 4'b0110;

endpackage

// File: rtl/pwc_sel_decode.sv
module pwc_sel_decode #(
  parameter int CHIP_W = 3
) (
  input  logic [7:0]        sel_byte,
  input  logic [CHIP_W-1:0] dev_sel,
  input  logic              locked,
  input  logic              busy,
  output logic              hit,
  output logic              to_prt
);
  import pwc_pkg::*;

  logic type_arr;
  logic type_prt;
  logic chip_ok;
  logic is_write;

  assign type_arr = (sel_byte[7:4] == TYPE_ARRAY);
  assign type_prt = (sel_byte[7:4] == TYPE_PROT) && !locked;
  assign chip_ok  = (sel_byte[CHIP_W:1] == dev_sel);
  assign is_write = !sel_byte[0];
  assign hit      = (type_arr || type_prt) && chip_ok && is_write && !busy;
  assign to_prt   = type_prt;

endmodule

// File: rtl/pwc_row_buf.sv
module pwc_row_buf #(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ROW_W-1:0]  wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  rslot,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int ROWN = 1 << ROW_W;

  logic [DATA_W-1:0] dat [ROWN];
  logic [ROWN-1:0]   vld;

  for (genvar g = 0; g < ROWN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               vld[g] <= 1'b0;
      else if (clr)                             vld[g] <= 1'b0;
      else if (we && (wslot == ROW_W'(g)))      vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we && (wslot == ROW_W'(g))) dat[g] <= wdata;
    end
  end

  assign rdata  = dat[rslot];
  assign rvalid = vld[rslot];

  // R9: a clear leaves no slot marked
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !we) |=> (vld == '0));

endmodule

// File: rtl/pwc_commit_engine.sv
module pwc_commit_engine #(
  parameter int ADDR_W    = 8,
  parameter int ROW_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-ROW_W-1:0] row_in,
  output logic                    busy,
  output logic [ROW_W-1:0]        slot,
  input  logic                    slot_valid,
  input  logic [DATA_W-1:0]       slot_data,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    done
);
  localparam int HI_W = ADDR_W - ROW_W;
  localparam int ROWN = 1 << ROW_W;
  localparam int CW   = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  logic            busy_q;
  logic [CW-1:0]   cnt_q;
  logic [HI_W-1:0] row_q;
  logic            in_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      row_q  <= row_in;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign in_row    = ({1'b0, cnt_q} < (CW+1)'(ROWN));
  assign slot      = cnt_q[ROW_W-1:0];
  assign mem_we    = busy_q && in_row && slot_valid;
  assign mem_addr  = {row_q, slot};
  assign mem_wdata = slot_data;
  assign done      = busy_q && (cnt_q == LAST);
  assign busy      = busy_q;

  // R7: the window closes right after its last counted cycle
  p_done_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy_q);

  // R7: a cycle is never restarted while one runs
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);

endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              guard_lo,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R8: once locked, no write reaches the lower half
  p_lower_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && guard_lo) |-> waddr[ADDR_W-1]);

endmodule

// File: rtl/prot_page_commit.sv
module prot_page_commit #(
  parameter int ADDR_W    = 8,
  parameter int ROW_W     = 4,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [7:0]        ev_byte,
  output logic              resp_valid,
  output logic              resp_ack,
  input  logic [2:0]        dev_sel,
  input  logic              wr_inhibit,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import pwc_pkg::*;

  localparam int HI_W   = ADDR_W - ROW_W;
  localparam int DATA_W = 8;

  sess_t            st_q, st_d;
  logic             mode_prt_q;
  logic             armed_q, armed_d;
  logic [HI_W-1:0]  row_q;
  logic [ROW_W-1:0] ptr_q;
  logic             resp_valid_q, resp_ack_q;
  logic             locked_q = 1'b0;

  logic             accept;
  ev_kind_t         kind;
  logic             sel_hit, sel_prt;
  logic             ack_d, dat_ok;
  logic             buf_we, buf_clr_cmd, start, set_lock;

  logic             eng_busy, eng_done, mem_we;
  logic [ROW_W-1:0] eng_slot;
  logic [DATA_W-1:0] slot_data, mem_wdata;
  logic             slot_valid;
  logic [ADDR_W-1:0] mem_addr;

  assign kind     = ev_kind_t'(ev_kind);
  assign ev_ready = !resp_valid_q;
  assign accept   = ev_valid && ev_ready;

  pwc_sel_decode #(.CHIP_W(3)) u_dec (
    .sel_byte (ev_byte),
    .dev_sel  (dev_sel),
    .locked   (locked_q),
    .busy     (eng_busy),
    .hit      (sel_hit),
    .to_prt   (sel_prt)
  );

  always_comb begin
    ack_d       = 1'b0;
    dat_ok      = 1'b0;
    st_d        = st_q;
    armed_d     = armed_q;
    buf_we      = 1'b0;
    buf_clr_cmd = 1'b0;
    start       = 1'b0;
    set_lock    = 1'b0;
    if (accept) begin
      unique case (kind)
        EV_SEL: begin
          ack_d       = sel_hit;
          st_d        = sel_hit ? SS_ADDR : SS_IDLE;
          armed_d     = 1'b0;
          buf_clr_cmd = !eng_busy;
        end
        EV_ADR: begin
          armed_d = 1'b0;
          if (st_q == SS_ADDR) begin
            ack_d = 1'b1;
            st_d  = SS_DATA;
          end else begin
            st_d  = SS_IDLE;
          end
        end
        EV_DAT: begin
          if (st_q == SS_DATA) begin
            dat_ok  = !wr_inhibit &&
                      (mode_prt_q || !(locked_q && !row_q[HI_W-1]));
            ack_d   = dat_ok;
            buf_we  = dat_ok && !mode_prt_q;
            armed_d = dat_ok;
          end else begin
            st_d    = SS_IDLE;
            armed_d = 1'b0;
          end
        end
        EV_STP: begin
          st_d    = SS_IDLE;
          armed_d = 1'b0;
          if ((st_q == SS_DATA) && armed_q && ev_byte[0]) begin
            set_lock = mode_prt_q;
            start    = !mode_prt_q;
          end else begin
            buf_clr_cmd = !eng_busy;
          end
        end
        default: st_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SS_IDLE;
      mode_prt_q   <= 1'b0;
      armed_q      <= 1'b0;
      row_q        <= '0;
      ptr_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      if (accept) begin
        resp_valid_q <= (kind != EV_STP);
        resp_ack_q   <= ack_d;
        if (kind == EV_SEL && sel_hit) mode_prt_q <= sel_prt;
        if (kind == EV_ADR && st_q == SS_ADDR) {row_q, ptr_q} <= ev_byte[ADDR_W-1:0];
        if (kind == EV_DAT && st_q == SS_DATA) ptr_q <= ptr_q + 1'b1;
      end else begin
        resp_valid_q <= 1'b0;
      end
    end
  end

  // Lock flag: no reset branch, it keeps its value across rst_n
  always_ff @(posedge clk) begin
    if (set_lock) locked_q <= 1'b1;
  end

  pwc_row_buf #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (buf_clr_cmd || eng_done),
    .we     (buf_we),
    .wslot  (ptr_q),
    .wdata  (ev_byte),
    .rslot  (eng_slot),
    .rdata  (slot_data),
    .rvalid (slot_valid)
  );

  pwc_commit_engine #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .row_in     (row_q),
    .busy       (eng_busy),
    .slot       (eng_slot),
    .slot_valid (slot_valid),
    .slot_data  (slot_data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done       (eng_done)
  );

  pwc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .waddr    (mem_addr),
    .wdata    (mem_wdata),
    .guard_lo (locked_q),
    .raddr    (rd_addr),
    .rdata    (rd_data)
  );

  assign resp_valid = resp_valid_q;
  assign resp_ack   = resp_ack_q;
  assign busy       = eng_busy;

  // R7: nothing accepted during the write cycle is acknowledged
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_q && $past(eng_busy)) |-> !resp_ack_q);

  // R3: no data acknowledge while the inhibit pin was high
  p_inhibit_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_q && resp_ack_q && $past(kind == EV_DAT)) |-> !$past(wr_inhibit));

  // R9: the lock never falls
  p_lock_sticky_r9: assert property (@(posedge clk)
    $past(locked_q) |-> locked_q);

  // R10: a response only follows an accepted non-STOP event
  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_q |-> $past(accept && (kind != EV_STP)));

endmodule

// File: tb/sim_prot_page_commit.sv
module sim_prot_page_commit;
  import pwc_pkg::*;

  localparam int WRC = 40;
  localparam logic [7:0] SA = 8'hAA;  // 1010 101 0
  localparam logic [7:0] SP = 8'h6A;  // 0110 101 0

  logic       clk = 1'b0, rst_n = 1'b0, ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_byte = 8'h00;
  logic [2:0] dev_sel = 3'b101;
  logic       wr_inhibit = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic       ev_ready, resp_valid, resp_ack, busy;
  logic [7:0] rd_data;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  prot_page_commit #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .dev_sel(dev_sel), .wr_inhibit(wr_inhibit),
    .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b, output logic v, output logic a);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
    v = resp_valid; a = resp_ack;
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] b, input logic exp_ack, input string tag);
    logic v, a;
    send(k, b, v, a);
    chk({tag, " resp_valid"}, v, 1);
    chk(tag, a, exp_ack);
  endtask

  task automatic open_sess(input logic [7:0] sel, input logic [7:0] adr, input string tag);
    put(EV_SEL, sel, 1'b1, {tag, " select"});
    put(EV_ADR, adr, 1'b1, {tag, " address"});
  endtask

  task automatic stop_len(input logic aligned, input int exp_len, input string tag);
    logic v, a;
    int n;
    send(EV_STP, {7'd0, aligned}, v, a);
    chk({tag, " stop no resp R10"}, v, 0);
    n = 0;
    while (busy && n < 4 * WRC) begin n++; @(negedge clk); end
    chk({tag, " busy length"}, n, exp_len);
  endtask

  task automatic byte_wr(input logic [7:0] adr, input logic [7:0] d, input string tag);
    open_sess(SA, adr, tag);
    put(EV_DAT, d, 1'b1, {tag, " data"});
    stop_len(1'b1, WRC, tag);
  endtask

  task automatic rd_chk(input logic [7:0] adr, input logic [7:0] exp, input string tag);
    @(negedge clk) rd_addr = adr;
    @(negedge clk) chk(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R7 busy after reset", busy, 0);
    chk("R10 ready after reset", ev_ready, 1);
    chk("R10 no resp after reset", resp_valid, 0);
  endtask

  task automatic t_byte_write();
    byte_wr(8'h35, 8'h5A, "R7 byte write");
    rd_chk(8'h35, 8'h5A, "R11 read back 35");
  endtask

  task automatic t_select();
    put(EV_SEL, 8'hA8, 1'b0, "R1 chip mismatch");
    put(EV_SEL, 8'hAB, 1'b0, "R1 read select");
    put(EV_SEL, 8'hFA, 1'b0, "R1 foreign type");
    put(EV_ADR, 8'h10, 1'b0, "R12 address outside session");
    put(EV_DAT, 8'h10, 1'b0, "R12 data outside session");
  endtask

  task automatic t_wrap();
    byte_wr(8'h50, 8'hEE, "R4 pre 50");
    open_sess(SA, 8'h4E, "R4 wrap");
    for (int i = 0; i < 18; i++) put(EV_DAT, 8'h80 + 8'(i), 1'b1, "R4 wrap data");
    stop_len(1'b1, WRC, "R4 wrap");
    rd_chk(8'h4E, 8'h90, "R4 slot E last wins");
    rd_chk(8'h4F, 8'h91, "R4 slot F last wins");
    rd_chk(8'h40, 8'h82, "R4 slot 0 wrapped");
    rd_chk(8'h4D, 8'h8F, "R4 slot D");
    rd_chk(8'h50, 8'hEE, "R4 next row untouched");
  endtask

  task automatic t_stop_place();
    byte_wr(8'h60, 8'h11, "R5 pre 60");
    open_sess(SA, 8'h60, "R5 misplaced");
    put(EV_DAT, 8'h22, 1'b1, "R5 data");
    stop_len(1'b0, 0, "R5 misplaced stop");
    rd_chk(8'h60, 8'h11, "R5 discarded");
    open_sess(SA, 8'h60, "R5 no data");
    stop_len(1'b1, 0, "R5 stop after address");
  endtask

  task automatic t_inhibit();
    byte_wr(8'h20, 8'h44, "R3 pre 20");
    wr_inhibit = 1'b1;
    open_sess(SA, 8'h20, "R2 address under inhibit");
    put(EV_DAT, 8'h55, 1'b0, "R3 data under inhibit");
    stop_len(1'b1, 0, "R3 stop after refusal");
    wr_inhibit = 1'b0;
    rd_chk(8'h20, 8'h44, "R3 unchanged");
  endtask

  task automatic t_keep_slots();
    open_sess(SA, 8'h70, "R6 pre");
    put(EV_DAT, 8'h01, 1'b1, "R6 pre d0");
    put(EV_DAT, 8'h02, 1'b1, "R6 pre d1");
    put(EV_DAT, 8'h03, 1'b1, "R6 pre d2");
    stop_len(1'b1, WRC, "R6 pre");
    open_sess(SA, 8'h70, "R6 mixed");
    put(EV_DAT, 8'hA1, 1'b1, "R6 first");
    @(negedge clk) wr_inhibit = 1'b1;
    put(EV_DAT, 8'hA2, 1'b0, "R6 refused middle");
    @(negedge clk) wr_inhibit = 1'b0;
    put(EV_DAT, 8'hA3, 1'b1, "R6 third");
    stop_len(1'b1, WRC, "R6 mixed");
    rd_chk(8'h70, 8'hA1, "R6 slot 0");
    rd_chk(8'h71, 8'h02, "R6 slot 1 kept");
    rd_chk(8'h72, 8'hA3, "R6 slot 2");
  endtask

  task automatic t_busy_refuse();
    logic v, a;
    int n;
    open_sess(SA, 8'hB0, "R7 busy");
    put(EV_DAT, 8'h3C, 1'b1, "R7 busy data");
    send(EV_STP, 8'h01, v, a);
    chk("R7 busy high after stop", busy, 1);
    put(EV_SEL, SA, 1'b0, "R7 select while busy");
    put(EV_ADR, 8'hB0, 1'b0, "R7 address while busy");
    n = 0;
    while (busy && n < 4 * WRC) begin n++; @(negedge clk); end
    chk("R7 busy ended", busy, 0);
    rd_chk(8'hB0, 8'h3C, "R7 commit after refusals");
  endtask

  task automatic t_protect();
    byte_wr(8'h10, 8'h77, "R8 pre 10");
    wr_inhibit = 1'b1;
    open_sess(SP, 8'h00, "R8 prot inhibited");
    put(EV_DAT, 8'h00, 1'b0, "R8 prot data inhibited");
    stop_len(1'b1, 0, "R8 prot inhibited");
    wr_inhibit = 1'b0;
    open_sess(SP, 8'h5C, "R8 prot still open");
    put(EV_DAT, 8'hC3, 1'b1, "R8 prot data");
    stop_len(1'b1, 0, "R8 prot commit");
    put(EV_SEL, SP, 1'b0, "R8 prot select after lock");
    open_sess(SA, 8'h10, "R8 lower");
    put(EV_DAT, 8'h99, 1'b0, "R8 lower refused");
    stop_len(1'b1, 0, "R8 lower");
    rd_chk(8'h10, 8'h77, "R8 lower unchanged");
    byte_wr(8'h90, 8'h6E, "R8 upper writable");
    rd_chk(8'h90, 8'h6E, "R8 upper value");
  endtask

  task automatic t_reset_keep();
    byte_wr(8'hC0, 8'h31, "R9 pre C0");
    open_sess(SA, 8'hC0, "R9 pending");
    put(EV_DAT, 8'h99, 1'b1, "R9 pending data");
    do_reset();
    stop_len(1'b1, 0, "R9 stop after reset");
    rd_chk(8'hC0, 8'h31, "R9 array kept");
    rd_chk(8'h90, 8'h6E, "R9 upper kept");
    put(EV_SEL, SP, 1'b0, "R9 lock kept prot select");
    open_sess(SA, 8'h10, "R9 lower");
    put(EV_DAT, 8'h12, 1'b0, "R9 lock kept lower");
    stop_len(1'b1, 0, "R9 lower");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_write();
    t_select();
    t_wrap();
    t_stop_place();
    t_inhibit();
    t_keep_slots();
    t_busy_refuse();
    t_protect();
    t_reset_keep();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule